// File: doc/BRIEF.md
# Sum-of-Products Logic Array with Output Feedback

This block models a small field-programmable sum-of-products device. The AND plane is programmable and the OR plane is fixed. Ten dedicated inputs and six fed-back output levels form sixteen array lines. Each line reaches every product term in both its true and complemented form.

The block has eight outputs. Each one owns eight product terms. Seven of them feed a fixed OR gate, and the output level is the complement of that OR. The eighth term decides whether the output pin is driven. No product term is shared between outputs.

The fuse pattern is shifted in one bit per clock after reset. Once the last bit is in, a done flag rises and the map is frozen until the next reset. The pad level and its enable come out as separate ports, so the surrounding logic can build the three-state pad.

Top module: `pal_top`

## Requirements
- R1: Reset returns the block to the erased state. In that state every fuse is intact, `cfgDone` is 0, every `padOe` bit is 0 and every `padVal` bit is 1.
- R2: While `cfgEn` is 1 and `cfgDone` is 0, one `cfgBit` is taken per rising clock edge. The first bit taken lands at fuse index 0. The fuse index is (out*8 + term)*32 + 2*line + pol, with these fields:
  - term 0..6 are the sum terms and term 7 is the enable term.
  - line 0..9 are `dataIn[0..9]` and line 10..15 are the fed-back levels of outputs 0..5.
  - pol 0 selects the true literal and pol 1 the complemented literal.
- R3: `cfgDone` rises on the edge that takes the 2048th bit and stays 1 until reset. While it is 1, `cfgEn` and `cfgBit` have no effect on the outputs.
- R4: A fuse bit of 1 (intact) puts its literal into the AND. A fuse bit of 0 (blown) contributes a constant 1. A term whose fuses are all blown evaluates to 1.
- R5: A term whose fuses are all intact evaluates to 0 and adds nothing to its output's sum.
- R6: `padVal[o]` is the complement of the OR of output o's seven sum terms. It responds to `dataIn` in the same cycle, with no clock edge in between.
- R7: `padOe[o]` equals output o's enable term.
- R8: The levels of outputs 0..5 are registered on every clock edge once `cfgDone` is 1, and they drive array lines 10..15. They are held while `cfgDone` is 0. A change therefore reaches a term one edge later, whatever the state of `padOe`.
- R9: Programming the terms of one output leaves every other output unchanged. An output whose terms stay intact keeps `padOe`=0 and `padVal`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; restores the erased map |
| cfgEn | input | 1 | Shift-enable for the fuse load |
| cfgBit | input | 1 | Serial fuse bit, first bit goes to index 0 |
| cfgDone | output | 1 | All fuse bits loaded; map frozen |
| dataIn | input | 10 | Dedicated array inputs |
| padVal | output | 8 | Output level (complement of sum of products) |
| padOe | output | 8 | Output drive enable from each enable term |

## Verification
Outputs that depend only on `dataIn` are due in the same cycle. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. A change that travels through a fed-back line is due one rising edge later. The feedback check first samples that the dependent output still holds its old value, then samples again after the next edge. `cfgDone` is checked in two places: just before the edge that takes the last bit, where it must still be 0, and on the falling edge after it, where it must be 1.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int DefInW   = 10;
  localparam int DefOutN  = 8;
  localparam int DefFbN   = 6;
  localparam int DefSumPt = 7;

  typedef struct packed {
    logic shift;   // accept one serial fuse bit this edge
    logic fbRun;   // let the feedback register follow the outputs
  } cfgStrobe_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int MAP_BITS = 2048,
  localparam int CNT_W   = $clog2(MAP_BITS)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEn,
  output cfgStrobe_t stb,
  output logic       cfgDone
);
  logic [CNT_W-1:0] bitCnt;
  logic             doneQ;

  assign stb.shift = cfgEn & ~doneQ;
  assign stb.fbRun = doneQ;
  assign cfgDone   = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else if (stb.shift) begin
      if (bitCnt == CNT_W'(MAP_BITS - 1)) begin
        bitCnt <= '0;
        doneQ  <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int LINE_N = 16,
  parameter int SUM_PT = 7,
  localparam int PT_FUSES = 2 * LINE_N,
  localparam int PT_N     = SUM_PT + 1
) (
  input  logic [PT_FUSES-1:0]      lits,
  input  logic [PT_N*PT_FUSES-1:0] fuses,
  output logic                     level,
  output logic                     enable
);
  logic [PT_N-1:0] ptVal;

  // intact fuse (1) passes the literal; blown fuse (0) forces a 1
  for (genvar t = 0; t < PT_N; t++) begin : g_pt
    assign ptVal[t] = &(~fuses[t*PT_FUSES +: PT_FUSES] | lits);
  end

  assign level  = ~(|ptVal[SUM_PT-1:0]);
  assign enable = ptVal[SUM_PT];
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int OUT_N  = 8,
  parameter int FB_N   = 6,
  parameter int SUM_PT = 7,
  localparam int LINE_N    = IN_W + FB_N,
  localparam int PT_FUSES  = 2 * LINE_N,
  localparam int OUT_FUSES = (SUM_PT + 1) * PT_FUSES,
  localparam int MAP_BITS  = OUT_N * OUT_FUSES
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       stb,
  input  logic             cfgBit,
  input  logic [IN_W-1:0]  dataIn,
  output logic [OUT_N-1:0] padVal,
  output logic [OUT_N-1:0] padOe
);
  logic [MAP_BITS-1:0] fuseMap;
  logic [FB_N-1:0]     fbReg;
  logic [LINE_N-1:0]   lines;
  logic [PT_FUSES-1:0] lits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fuseMap <= '1;
    else if (stb.shift) fuseMap <= {cfgBit, fuseMap[MAP_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fbReg <= '1;
    else if (stb.fbRun) fbReg <= padVal[FB_N-1:0];
  end

  assign lines = {fbReg, dataIn};

  for (genvar k = 0; k < LINE_N; k++) begin : g_lit
    assign lits[2*k]   = lines[k];
    assign lits[2*k+1] = ~lines[k];
  end

  for (genvar o = 0; o < OUT_N; o++) begin : g_out
    pal_macrocell #(.LINE_N(LINE_N), .SUM_PT(SUM_PT)) u_mc (
      .lits  (lits),
      .fuses (fuseMap[o*OUT_FUSES +: OUT_FUSES]),
      .level (padVal[o]),
      .enable(padOe[o])
    );
  end
endmodule

// File: rtl/pal_top.sv
module pal_top
  import pal_pkg::*;
#(
  parameter int IN_W   = DefInW,
  parameter int OUT_N  = DefOutN,
  parameter int FB_N   = DefFbN,
  parameter int SUM_PT = DefSumPt,
  localparam int LINE_N   = IN_W + FB_N,
  localparam int MAP_BITS = OUT_N * (SUM_PT + 1) * 2 * LINE_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEn,
  input  logic             cfgBit,
  output logic             cfgDone,
  input  logic [IN_W-1:0]  dataIn,
  output logic [OUT_N-1:0] padVal,
  output logic [OUT_N-1:0] padOe
);
  cfgStrobe_t stb;

  pal_ctrl #(.MAP_BITS(MAP_BITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgEn  (cfgEn),
    .stb    (stb),
    .cfgDone(cfgDone)
  );

  pal_datapath #(
    .IN_W(IN_W), .OUT_N(OUT_N), .FB_N(FB_N), .SUM_PT(SUM_PT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .cfgBit(cfgBit),
    .dataIn(dataIn),
    .padVal(padVal),
    .padOe (padOe)
  );
endmodule

// File: rtl/pal_checker.sv
module pal_checker #(
  parameter int OUT_N    = 8,
  parameter int FB_N     = 6,
  parameter int MAP_BITS = 2048,
  localparam int CNT_W   = $clog2(MAP_BITS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgEn,
  input logic                cfgDone,
  input logic [OUT_N-1:0]    padVal,
  input logic [OUT_N-1:0]    padOe,
  input logic [CNT_W-1:0]    bitCnt,
  input logic [MAP_BITS-1:0] fuseMap,
  input logic [FB_N-1:0]     fbReg
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_ERASED_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDone && bitCnt == '0) |-> (padOe == '0 && padVal == '1)); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> cfgDone); // R3

  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> $stable(fuseMap)); // R3

  AST_DONE_AT_LAST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(cfgDone)) |-> ($past(bitCnt) == CNT_W'(MAP_BITS - 1) && $past(cfgEn))); // R2

  AST_FB_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(cfgDone)) |-> (fbReg == $past(padVal[FB_N-1:0]))); // R8

  AST_FB_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(cfgDone)) |-> $stable(fbReg)); // R8
endmodule

bind pal_top pal_checker #(
  .OUT_N(OUT_N), .FB_N(FB_N), .MAP_BITS(MAP_BITS)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .cfgEn  (cfgEn),
  .cfgDone(cfgDone),
  .padVal (padVal),
  .padOe  (padOe),
  .bitCnt (u_ctrl.bitCnt),
  .fuseMap(u_dp.fuseMap),
  .fbReg  (u_dp.fbReg)
);

// File: tb/pal_top_tb_top.sv
`timescale 1ns/1ps
module pal_top_tb_top;
  localparam int MAP = 2048;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEn = 1'b0;
  logic       cfgBit = 1'b0;
  logic       cfgDone;
  logic [9:0] dataIn = '0;
  logic [7:0] padVal;
  logic [7:0] padOe;

  int nChk = 0;
  int nFail = 0;
  logic [MAP-1:0] fm;

  always #2 clk = ~clk;  // 250 MHz

  pal_top dut_i (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .dataIn(dataIn), .padVal(padVal), .padOe(padOe)
  );

  function automatic int fidx(int o, int t, int line, int pol);
    return (o*8 + t)*32 + 2*line + pol;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic blowTerm(int o, int t);
    for (int f = 0; f < 32; f++) fm[fidx(o, t, 0, 0) + f] = 1'b0;
  endtask

  // drive at falling edge, sample 1 ns later
  task automatic drive(logic [9:0] v);
    @(negedge clk);
    dataIn = v;
    #1;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 done", {7'b0, cfgDone}, 8'h00);
    chk("R1 oe", padOe, 8'h00);
    chk("R1 val", padVal, 8'hFF);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tLoad();
    fm = '1;
    // output 7: sum = in0&in1 | ~in2, enable always on
    blowTerm(7, 0); fm[fidx(7, 0, 0, 0)] = 1'b1; fm[fidx(7, 0, 1, 0)] = 1'b1;
    blowTerm(7, 1); fm[fidx(7, 1, 2, 1)] = 1'b1;
    blowTerm(7, 7);
    // output 6: sum = in4, enable = in3
    blowTerm(6, 0); fm[fidx(6, 0, 4, 0)] = 1'b1;
    blowTerm(6, 7); fm[fidx(6, 7, 3, 0)] = 1'b1;
    // output 0: sum = in5, enable left intact (off)
    blowTerm(0, 0); fm[fidx(0, 0, 5, 0)] = 1'b1;
    // output 1: sum = feedback line 10 (output 0 level), enable on
    blowTerm(1, 0); fm[fidx(1, 0, 10, 0)] = 1'b1;
    blowTerm(1, 7);
    for (int i = 0; i < MAP; i++) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgBit = fm[i];
      if (i == MAP - 1) begin
        #1;
        chk("R3 not early", {7'b0, cfgDone}, 8'h00);
      end
    end
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    chk("R3 done", {7'b0, cfgDone}, 8'h01);
  endtask

  task automatic tSum();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      drive({7'b0, c, b, a});
      chk("R6 R4 R5 out7", {7'b0, padVal[7]}, {7'b0, ~((a & b) | ~c)});
    end
    chk("R4 blown enable", {7'b0, padOe[7]}, 8'h01);
  endtask

  task automatic tEnable();
    drive(10'b00_0001_0000);
    chk("R7 oe6 off", {7'b0, padOe[6]}, 8'h00);
    chk("R6 val6", {7'b0, padVal[6]}, 8'h00);
    drive(10'b00_0000_1000);
    chk("R7 oe6 on", {7'b0, padOe[6]}, 8'h01);
    chk("R6 val6 hi", {7'b0, padVal[6]}, 8'h01);
  endtask

  task automatic tFeedback();
    drive(10'b0);
    @(negedge clk); #1;
    chk("R8 settle", {7'b0, padVal[1]}, 8'h00);
    drive(10'b00_0010_0000);  // in5 = 1
    chk("R8 out0 disabled", {7'b0, padOe[0]}, 8'h00);
    chk("R6 out0 level", {7'b0, padVal[0]}, 8'h00);
    chk("R8 one edge late", {7'b0, padVal[1]}, 8'h00);
    @(negedge clk); #1;
    chk("R8 after edge", {7'b0, padVal[1]}, 8'h01);
  endtask

  task automatic tIsolation();
    drive(10'h3FF);
    chk("R9 oe untouched", padOe & 8'h3C, 8'h00);
    chk("R9 val untouched", padVal & 8'h3C, 8'h3C);
  endtask

  task automatic tIgnore();
    logic [7:0] v0, e0;
    drive(10'b00_0001_1011);
    @(negedge clk); #1;
    v0 = padVal; e0 = padOe;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgBit = i[0];
    end
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    chk("R3 val unchanged", padVal, v0);
    chk("R3 oe unchanged", padOe, e0);
    chk("R3 still done", {7'b0, cfgDone}, 8'h01);
  endtask

  initial begin
    #(100000 * 4);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    tReset();
    tLoad();
    tSum();
    tEnable();
    tFeedback();
    tIsolation();
    tIgnore();
    tReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule